// File: doc/BRIEF.md
# Coincidence Track Finder with Loadable Momentum Table

This block finds the best muon track candidate inside one cluster of eight neighbouring sub-sectors. Each clock cycle it receives one radial hit word and two azimuthal hit words. The radial word gives the radial sub-sector position and the radial deviation. Each azimuthal word gives a hit flag and the azimuthal deviation. The radial word is paired with each azimuthal word to form one lookup address per candidate. Each address reads a table held in synchronous RAM, and the entry read back gives that candidate's momentum level and charge sign.

Both candidates share one radial position. Of the two, only the one with the higher momentum level is kept, and the other is dropped as a fake. The output gives that track's level, its sign, the radial sub-sector of its hit and which azimuthal word produced it.

The table is loaded through a configuration write port, so the momentum algorithm can be changed without changing any logic. The pipeline has no dead time and accepts a new input set on every clock edge. The default widths keep the table small. The full-size geometry is reached by changing the parameters.

Top module: `trk_coinc_finder`

## Requirements
- R1: While `rst` is high on a clock edge, the outputs after that edge are all zero: `trk_valid`, `trk_pt`, `trk_neg`, `trk_sub` and `trk_cand`.
- R2: A table entry is 4 bits. Bit 3 is the negative-charge flag and bits 2:0 are the momentum code, where 0 means no track and 1 to 6 are the levels. The entry for a candidate sits at address `{rad_pos, rad_dev, azN_dev}`. When `cfg_we` is high on an edge, `cfg_data` is stored at `cfg_addr` in the table used by both candidates. A later overwrite takes effect on later lookups.
- R3: The result for inputs sampled at clock edge n appears on the outputs after edge n+1. A new input set is accepted on every edge, and back-to-back inputs produce back-to-back results.
- R4: A candidate whose hit flag (`az0_hit` or `az1_hit`) is low contributes no track, whatever its table entry holds.
- R5: When both candidates are present, the one with the larger momentum code wins. `trk_cand` is 0 for the first azimuthal word and 1 for the second.
- R6: When both candidates have equal nonzero codes, the first azimuthal word (candidate 0) wins.
- R7: `trk_valid` is high exactly when the winning code is nonzero. While it is low, `trk_pt`, `trk_neg`, `trk_sub` and `trk_cand` are all zero.
- R8: When a track is valid, `trk_sub` equals the `rad_pos` value that was sampled with it.
- R9: `trk_neg` is bit 3 of the winning candidate's table entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rad_pos | input | RPW (3) | Radial sub-sector position of the hit |
| rad_dev | input | RDW (3) | Radial deviation |
| az0_hit | input | 1 | Azimuthal word 0 carries a hit |
| az0_dev | input | PDW (3) | Azimuthal deviation of word 0 |
| az1_hit | input | 1 | Azimuthal word 1 carries a hit |
| az1_dev | input | PDW (3) | Azimuthal deviation of word 1 |
| cfg_we | input | 1 | Table write enable |
| cfg_addr | input | RPW+RDW+PDW (9) | Table write address |
| cfg_data | input | 4 | Table entry: bit 3 negative sign, bits 2:0 momentum code |
| trk_valid | output | 1 | A track was found |
| trk_pt | output | 3 | Momentum code of the winning track |
| trk_neg | output | 1 | Charge sign of the winning track |
| trk_sub | output | RPW (3) | Radial sub-sector of the winning hit |
| trk_cand | output | 1 | Index of the winning azimuthal word |

## Verification
The hardest case to reach from the ports is a contest in which the two candidates resolve through different table entries whose codes are chosen on purpose: a tie, a reversed order, or a present hit competing with an absent one that holds a large entry. A table filled with a pattern seldom produces these cases by chance. So the bench first fills the whole table with a computed pattern. Then, before each contest, it overwrites the two exact entries that the contest will address. Finally it drives a long back-to-back stream with a latency-aligned model, so that each result is matched to the input set it came from.

// File: rtl/tcf_pkg.sv
package tcf_pkg;
  localparam int PT_W    = 3;
  localparam int ENTRY_W = PT_W + 1;
  localparam int NCAND   = 2;

  typedef struct packed {
    logic            neg;
    logic [PT_W-1:0] pt;
  } tcf_entry_t;
endpackage

// File: rtl/tcf_lut_bank.sv
module tcf_lut_bank
  import tcf_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic       clk,
  input  logic       we,
  input  logic [AW-1:0] waddr,
  input  tcf_entry_t wdata,
  input  logic [AW-1:0] raddr,
  output tcf_entry_t rdata
);
  localparam int DEPTH = 1 << AW;

  tcf_entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tcf_best_select.sv
module tcf_best_select
  import tcf_pkg::*;
#(
  parameter int SW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  tcf_entry_t      ent0,
  input  tcf_entry_t      ent1,
  input  logic [1:0]      hit,
  input  logic [SW-1:0]   sub_in,
  output logic            valid,
  output logic [PT_W-1:0] pt,
  output logic            neg,
  output logic [SW-1:0]   sub,
  output logic            cand
);
  logic [PT_W-1:0] code0, code1, best_pt;
  logic            pick1, best_neg;

  always_comb begin
    code0    = hit[0] ? ent0.pt : '0;
    code1    = hit[1] ? ent1.pt : '0;
    pick1    = code1 > code0;
    best_pt  = pick1 ? code1 : code0;
    best_neg = pick1 ? ent1.neg : ent0.neg;
  end

  always_ff @(posedge clk) begin
    if (rst || best_pt == '0) begin
      valid <= 1'b0;
      pt    <= '0;
      neg   <= 1'b0;
      sub   <= '0;
      cand  <= 1'b0;
    end else begin
      valid <= 1'b1;
      pt    <= best_pt;
      neg   <= best_neg;
      sub   <= sub_in;
      cand  <= pick1;
    end
  end

  // R1: reset on an edge leaves the outputs cleared
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> !valid && pt == '0 && sub == '0);

  // R7: an idle output carries no stale fields
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (rst)
    !valid |-> (pt == '0 && !neg && sub == '0 && !cand));
endmodule

// File: rtl/trk_coinc_finder.sv
module trk_coinc_finder
  import tcf_pkg::*;
#(
  parameter int RPW = 3,
  parameter int RDW = 3,
  parameter int PDW = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [RPW-1:0]         rad_pos,
  input  logic [RDW-1:0]         rad_dev,
  input  logic                   az0_hit,
  input  logic [PDW-1:0]         az0_dev,
  input  logic                   az1_hit,
  input  logic [PDW-1:0]         az1_dev,
  input  logic                   cfg_we,
  input  logic [RPW+RDW+PDW-1:0] cfg_addr,
  input  logic [3:0]             cfg_data,
  output logic                   trk_valid,
  output logic [2:0]             trk_pt,
  output logic                   trk_neg,
  output logic [RPW-1:0]         trk_sub,
  output logic                   trk_cand
);
  localparam int AW = RPW + RDW + PDW;

  logic [PDW-1:0] az_dev [NCAND];
  logic [AW-1:0]  rd_addr [NCAND];
  tcf_entry_t     rd_ent [NCAND];
  tcf_entry_t     wr_ent;
  logic [1:0]     hit_q;
  logic [RPW-1:0] sub_q;

  assign az_dev[0] = az0_dev;
  assign az_dev[1] = az1_dev;
  assign wr_ent    = tcf_entry_t'(cfg_data);

  for (genvar g = 0; g < NCAND; g++) begin : g_cand
    assign rd_addr[g] = {rad_pos, rad_dev, az_dev[g]};
    tcf_lut_bank #(.AW(AW)) u_bank (
      .clk  (clk),
      .we   (cfg_we),
      .waddr(cfg_addr),
      .wdata(wr_ent),
      .raddr(rd_addr[g]),
      .rdata(rd_ent[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= '0;
      sub_q <= '0;
    end else begin
      hit_q <= {az1_hit, az0_hit};
      sub_q <= rad_pos;
    end
  end

  tcf_best_select #(.SW(RPW)) u_sel (
    .clk   (clk),
    .rst   (rst),
    .ent0  (rd_ent[0]),
    .ent1  (rd_ent[1]),
    .hit   (hit_q),
    .sub_in(sub_q),
    .valid (trk_valid),
    .pt    (trk_pt),
    .neg   (trk_neg),
    .sub   (trk_sub),
    .cand  (trk_cand)
  );

  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  // R4: no hit flags two edges back means no track now
  p_nohit_notrack_r4: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2 && !$past(az0_hit, 2) && !$past(az1_hit, 2)) |-> !trk_valid);

  // R8: reported sub-sector follows the radial input through the pipeline
  p_sub_aligned_r8: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2 && trk_valid) |-> trk_sub == $past(rad_pos, 2));

  // R5: candidate 1 can only win if its hit flag was set
  p_cand1_hit_r5: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2 && trk_valid && trk_cand) |-> $past(az1_hit, 2));
endmodule

// File: tb/tb_trk_coinc_finder.sv
module tb_trk_coinc_finder;
  localparam int RPW = 3, RDW = 3, PDW = 3;
  localparam int AW = RPW + RDW + PDW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [RPW-1:0] rad_pos = '0;
  logic [RDW-1:0] rad_dev = '0;
  logic az0_hit = 1'b0, az1_hit = 1'b0;
  logic [PDW-1:0] az0_dev = '0, az1_dev = '0;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [3:0] cfg_data = '0;
  logic trk_valid, trk_neg, trk_cand;
  logic [2:0] trk_pt;
  logic [RPW-1:0] trk_sub;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [3:0] tbl [DEPTH];

  always #5 clk = ~clk;

  trk_coinc_finder #(.RPW(RPW), .RDW(RDW), .PDW(PDW)) dut (
    .clk(clk), .rst(rst), .rad_pos(rad_pos), .rad_dev(rad_dev),
    .az0_hit(az0_hit), .az0_dev(az0_dev), .az1_hit(az1_hit), .az1_dev(az1_dev),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .trk_valid(trk_valid), .trk_pt(trk_pt), .trk_neg(trk_neg),
    .trk_sub(trk_sub), .trk_cand(trk_cand));

  // packed result {valid, pt[2:0], neg, sub[2:0], cand}
  function automatic logic [8:0] model(logic [2:0] rp, logic [2:0] rd,
      logic h0, logic [2:0] d0, logic h1, logic [2:0] d1);
    logic [3:0] e0, e1, w;
    logic [2:0] c0, c1;
    logic p1;
    e0 = tbl[{rp, rd, d0}];
    e1 = tbl[{rp, rd, d1}];
    c0 = h0 ? e0[2:0] : 3'd0;
    c1 = h1 ? e1[2:0] : 3'd0;
    p1 = c1 > c0;
    w  = p1 ? e1 : e0;
    if ((p1 ? c1 : c0) == 3'd0) return 9'd0;
    return {1'b1, w[2:0], w[3], rp, p1};
  endfunction

  function automatic logic [8:0] got();
    return {trk_valid, trk_pt, trk_neg, trk_sub, trk_cand};
  endfunction

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [3:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    tbl[a] = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drive(logic [2:0] rp, logic [2:0] rd, logic h0,
      logic [2:0] d0, logic h1, logic [2:0] d1);
    rad_pos = rp; rad_dev = rd; az0_hit = h0; az0_dev = d0;
    az1_hit = h1; az1_dev = d1;
  endtask

  task automatic one(string req, logic [2:0] rp, logic [2:0] rd, logic h0,
      logic [2:0] d0, logic h1, logic [2:0] d1);
    @(negedge clk);
    drive(rp, rd, h0, d0, h1, d1);
    @(negedge clk);
    @(negedge clk);
    check(req, got(), model(rp, rd, h0, d0, h1, d1));
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 reset outputs", got(), 9'd0);
    rst = 1'b0;
  endtask

  task automatic t_fill();
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = AW'(a);
      cfg_data = {1'(a[0] ^ a[4]), 3'((a * 5 + 1) % 7)};
      tbl[a] = cfg_data;
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_single();
    one("R2 R9 single cand0", 3'd2, 3'd5, 1, 3'd3, 0, 3'd0);
    one("R2 R8 single cand1", 3'd7, 3'd1, 0, 3'd0, 1, 3'd6);
    one("R8 single cand0 pos0", 3'd0, 3'd4, 1, 3'd2, 0, 3'd7);
  endtask

  task automatic t_nohit();
    wr({3'd4, 3'd2, 3'd1}, 4'hE);
    wr({3'd4, 3'd2, 3'd5}, 4'h6);
    one("R4 R7 both flags low", 3'd4, 3'd2, 0, 3'd1, 0, 3'd5);
    wr({3'd4, 3'd2, 3'd3}, 4'h1);
    one("R4 absent cand1 big entry", 3'd4, 3'd2, 1, 3'd3, 0, 3'd1);
    check("R5 low code present wins", {got()[8], got()[7:5], got()[0]}, {1'b1, 3'd1, 1'b0});
    wr({3'd4, 3'd2, 3'd3}, 4'h0);
    one("R7 zero code no track", 3'd4, 3'd2, 1, 3'd3, 0, 3'd1);
  endtask

  task automatic t_compete();
    wr({3'd1, 3'd6, 3'd0}, 4'h2);
    wr({3'd1, 3'd6, 3'd7}, 4'hD);
    one("R5 cand1 higher", 3'd1, 3'd6, 1, 3'd0, 1, 3'd7);
    check("R5 cand1 higher fields", got(), {1'b1, 3'd5, 1'b1, 3'd1, 1'b1});
    one("R5 cand0 higher", 3'd1, 3'd6, 1, 3'd7, 1, 3'd0);
    check("R5 cand0 higher fields", got(), {1'b1, 3'd5, 1'b1, 3'd1, 1'b0});
  endtask

  task automatic t_tie();
    wr({3'd6, 3'd3, 3'd2}, 4'h4);
    wr({3'd6, 3'd3, 3'd4}, 4'hC);
    one("R6 tie", 3'd6, 3'd3, 1, 3'd2, 1, 3'd4);
    check("R6 R9 tie fields", got(), {1'b1, 3'd4, 1'b0, 3'd6, 1'b0});
    one("R6 R9 tie swapped", 3'd6, 3'd3, 1, 3'd4, 1, 3'd2);
    check("R9 tie swapped sign", got(), {1'b1, 3'd4, 1'b1, 3'd6, 1'b0});
  endtask

  task automatic t_rewrite();
    wr({3'd3, 3'd3, 3'd3}, 4'h3);
    one("R2 before overwrite", 3'd3, 3'd3, 1, 3'd3, 0, 3'd0);
    wr({3'd3, 3'd3, 3'd3}, 4'hE);
    one("R2 after overwrite", 3'd3, 3'd3, 1, 3'd3, 0, 3'd0);
    check("R2 overwrite fields", got(), {1'b1, 3'd6, 1'b1, 3'd3, 1'b0});
  endtask

  task automatic t_stream();
    logic [8:0] hist [64];
    for (int i = 0; i < 42; i++) begin
      @(negedge clk);
      if (i >= 2) check("R3 back-to-back stream", got(), hist[i-2]);
      if (i < 40) begin
        logic [2:0] rp, rd, d0, d1;
        logic h0, h1;
        rp = 3'(i * 3); rd = 3'(i * 5 + 1); d0 = 3'(i); d1 = 3'(7 - i);
        h0 = (i % 3) != 0; h1 = (i % 4) != 1;
        drive(rp, rd, h0, d0, h1, d1);
        hist[i] = model(rp, rd, h0, d0, h1, d1);
      end
    end
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    drive(3'd5, 3'd5, 1, 3'd5, 1, 3'd5);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 reset mid-traffic", got(), 9'd0);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R3 first result after reset", got(), model(3'd5, 3'd5, 1, 3'd5, 1, 3'd5));
  endtask

  initial begin
    t_reset();
    t_fill();
    t_single();
    t_nohit();
    t_compete();
    t_tie();
    t_rewrite();
    t_stream();
    t_reset_mid();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R3 watchdog got hang exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule